// File: doc/BRIEF.md
# Four-Line Six-Level Subset Detector

This block is the receive-side detector for a code that carries 7 bits per symbol over 4 parallel lines. Each line is driven at one of six evenly spaced amplitudes. The six amplitudes are split into two interleaved groups of three, called A and B. In any one symbol all four lines use the same group. That group choice is itself one bit of the payload. The other six bits come from the position of the lines inside the chosen group, taken two lines at a time. The one pair position in which both lines sit at the lowest level of the group is never sent, which leaves 128 legal symbols.

The detector takes four signed, quantized samples. It decides which group is closer in summed squared distance, without computing any squares. Each line contributes a piecewise-linear term whose breakpoints are exactly the thresholds of that line's slicers. The block slices every line against both groups at the same time and decodes each pair of lines for both groups. It then keeps the six bits that belong to the winning group, and the group decision becomes the top bit. A flag marks symbols that land on the excluded pair position. Results appear on the outputs two clock cycles after the samples are presented.

Top module: `pam6SubsetDetector`

## Requirements
- R1: A symbol accepted with `inValid` high at a rising clock edge appears on the outputs with `outValid` high exactly two rising edges later. `outValid` is low in every cycle that does not correspond to an accepted symbol.
- R2: The amplitudes, in units of `UNIT`, are -5, -1 and +3 for group A, and -3, +1 and +5 for group B. `outData[6]` is 0 when the sum over the four lines of the squared distance to the nearest A amplitude is less than or equal to the same sum for B. Otherwise it is 1, so a tie resolves to A.
- R3: Per-line level index within A: 0 when x < -3·UNIT, 1 when -3·UNIT ≤ x < UNIT, and 2 when x ≥ UNIT. Within B: 0 when x < -UNIT, 1 when -UNIT ≤ x < 3·UNIT, and 2 when x ≥ 3·UNIT.
- R4: A pair of level indices (first, second) maps to 3 bits as follows: (0,1)=000, (0,2)=001, (1,2)=011, (1,1)=010, (1,0)=110, (2,0)=111, (2,1)=101, (2,2)=100. Lines 0 and 1, with line 0 as first, give `outData[2:0]`. Lines 2 and 3, with line 2 as first, give `outData[5:3]`.
- R5: `outBad` is 1 when either pair of the chosen group has indices (0,0). Such a pair contributes 000 to its three data bits.
- R6: Between accepted symbols, `outData` and `outBad` keep the values of the last delivered symbol.
- R7: While reset is asserted, and until the first symbol is delivered, `outValid`, `outData` and `outBad` are all 0.
- R8: Symbols presented on consecutive cycles are each delivered, in order, on consecutive cycles.
- R9: Every one of the 128 legal symbols, when sent at its noiseless amplitudes, is recovered exactly, with `outBad` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Samples on `inSamples` are a symbol to detect |
| inSamples | input | 4·SAMPLE_W | Four two's-complement samples; line k occupies bits [k·SAMPLE_W +: SAMPLE_W] |
| outValid | output | 1 | A detected symbol is on `outData` this cycle |
| outData | output | 7 | Bit 6 is the group decision; bits 5:0 are the pair bits |
| outBad | output | 1 | The detected symbol falls on the excluded pair position |

## Verification
The assertions assume that `inValid` is a known value in every cycle and that reset is held across at least one rising edge. Only on that basis do the pipeline-latency and hold properties hold from the first enabled cycle onward. The stimulus drives `inValid` low throughout reset and changes inputs only at falling edges. It mixes noisy points around legal amplitudes, samples anywhere in the signed range, and a sweep of all 128 noiseless symbols. The valid pattern has random gaps between symbols, so the hold behaviour and back-to-back delivery are both exercised. Directed samples sit exactly on every slicer threshold and on the tie between groups.

// File: rtl/pam6SubsetPkg.sv
package pam6SubsetPkg;
  localparam int NUM_LINES = 4;
  localparam int NUM_PAIRS = NUM_LINES / 2;
  localparam int PAIR_BITS = 3;
  localparam int DATA_W    = NUM_PAIRS * PAIR_BITS + 1;

  // Thermometer code of one line slice: bit1 = lower threshold met,
  // bit0 = upper threshold met. 00 -> index 0, 10 -> 1, 11 -> 2.
  typedef logic [1:0] thermo_t;

  typedef struct packed {
    logic ldStage1;
    logic ldStage2;
  } strobe_t;
endpackage

// File: rtl/pam6LineSlicer.sv
module pam6LineSlicer #(
  parameter int SAMPLE_W = 6,
  parameter int UNIT     = 1,
  localparam int TERM_W  = SAMPLE_W + 3
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  output logic [1:0]                 thermoA,
  output logic [1:0]                 thermoB,
  output logic signed [TERM_W-1:0]   term
);
  localparam logic signed [TERM_W-1:0] U1 = TERM_W'(UNIT);
  localparam logic signed [TERM_W-1:0] U2 = TERM_W'(2 * UNIT);
  localparam logic signed [TERM_W-1:0] U3 = TERM_W'(3 * UNIT);
  localparam logic signed [TERM_W-1:0] U4 = TERM_W'(4 * UNIT);

  logic signed [TERM_W-1:0] xe;
  logic geAlo, geBlo, geAhi, geBhi;

  assign xe = TERM_W'(sample);

  // Four comparators serve both the slicers and the distance term.
  assign geAlo = (xe >= -U3);
  assign geBlo = (xe >= -U1);
  assign geAhi = (xe >= U1);
  assign geBhi = (xe >= U3);

  assign thermoA = {geAlo, geAhi};
  assign thermoB = {geBlo, geBhi};

  // One quarter of (distance to nearest A)^2 - (distance to nearest B)^2.
  always_comb begin
    if (!geAlo)      term = xe + U4;
    else if (!geBlo) term = -xe - U2;
    else if (!geAhi) term = xe;
    else if (!geBhi) term = -xe + U2;
    else             term = xe - U4;
  end
endmodule

// File: rtl/pam6PairDecode.sv
module pam6PairDecode
  import pam6SubsetPkg::*;
(
  input  thermo_t              first,
  input  thermo_t              second,
  output logic [PAIR_BITS-1:0] code,
  output logic                 bad
);
  always_comb begin
    bad  = 1'b0;
    code = '0;
    unique case ({first, second})
      4'b0000: bad  = 1'b1;
      4'b0010: code = 3'b000;
      4'b0011: code = 3'b001;
      4'b1011: code = 3'b011;
      4'b1010: code = 3'b010;
      4'b1000: code = 3'b110;
      4'b1100: code = 3'b111;
      4'b1110: code = 3'b101;
      4'b1111: code = 3'b100;
      default: code = '0;
    endcase
  end
endmodule

// File: rtl/pam6Control.sv
module pam6Control
  import pam6SubsetPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    inValid,
  output strobe_t strobe,
  output logic    outValid
);
  logic s1Valid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid  <= 1'b0;
      outValid <= 1'b0;
    end else begin
      s1Valid  <= inValid;
      outValid <= s1Valid;
    end
  end

  assign strobe.ldStage1 = inValid;
  assign strobe.ldStage2 = s1Valid;

  a_r1_valid_two_cycles: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> ##1 outValid);
  a_r1_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ##1 !outValid);
endmodule

// File: rtl/pam6Datapath.sv
module pam6Datapath
  import pam6SubsetPkg::*;
#(
  parameter int SAMPLE_W = 6,
  parameter int UNIT     = 1
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  strobe_t                         strobe,
  input  logic [NUM_LINES*SAMPLE_W-1:0]   inSamples,
  output logic [DATA_W-1:0]               outData,
  output logic                            outBad
);
  localparam int TERM_W = SAMPLE_W + 3;
  localparam int SUM_W  = TERM_W + $clog2(NUM_LINES);
  localparam int WORD_W = NUM_PAIRS * PAIR_BITS;

  thermo_t                  thA  [NUM_LINES];
  thermo_t                  thB  [NUM_LINES];
  thermo_t                  thAR [NUM_LINES];
  thermo_t                  thBR [NUM_LINES];
  logic signed [TERM_W-1:0] termW [NUM_LINES];
  logic signed [SUM_W-1:0]  sumNext, sumR;

  for (genvar g = 0; g < NUM_LINES; g++) begin : gLine
    pam6LineSlicer #(.SAMPLE_W(SAMPLE_W), .UNIT(UNIT)) uSlice (
      .sample  (inSamples[g*SAMPLE_W +: SAMPLE_W]),
      .thermoA (thA[g]),
      .thermoB (thB[g]),
      .term    (termW[g])
    );
  end

  always_comb begin
    sumNext = '0;
    for (int k = 0; k < NUM_LINES; k++) sumNext = sumNext + SUM_W'(termW[k]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < NUM_LINES; k++) begin
        thAR[k] <= '0;
        thBR[k] <= '0;
      end
      sumR <= '0;
    end else if (strobe.ldStage1) begin
      for (int k = 0; k < NUM_LINES; k++) begin
        thAR[k] <= thA[k];
        thBR[k] <= thB[k];
      end
      sumR <= sumNext;
    end
  end

  // Stage 2: group decision, pair decode for both groups, selection.
  logic              pickB;
  logic [WORD_W-1:0] wordA, wordB, wordSel;
  logic [NUM_PAIRS-1:0] badA, badB;

  assign pickB = (sumR > 0);

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : gPair
    pam6PairDecode uDecA (
      .first  (thAR[2*p]),
      .second (thAR[2*p+1]),
      .code   (wordA[p*PAIR_BITS +: PAIR_BITS]),
      .bad    (badA[p])
    );
    pam6PairDecode uDecB (
      .first  (thBR[2*p]),
      .second (thBR[2*p+1]),
      .code   (wordB[p*PAIR_BITS +: PAIR_BITS]),
      .bad    (badB[p])
    );
  end

  for (genvar b = 0; b < WORD_W; b++) begin : gMux
    assign wordSel[b] = pickB ? wordB[b] : wordA[b];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outData <= '0;
      outBad  <= 1'b0;
    end else if (strobe.ldStage2) begin
      outData <= {pickB, wordSel};
      outBad  <= pickB ? (|badB) : (|badA);
    end
  end

  a_r5_bad_pair_zero: assert property (@(posedge clk) disable iff (!rstN)
    outBad |-> (outData[2:0] == 3'b000 || outData[5:3] == 3'b000));
endmodule

// File: rtl/pam6SubsetDetector.sv
module pam6SubsetDetector
  import pam6SubsetPkg::*;
#(
  parameter int SAMPLE_W = 6,
  parameter int UNIT     = 1
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          inValid,
  input  logic [4*SAMPLE_W-1:0]         inSamples,
  output logic                          outValid,
  output logic [6:0]                    outData,
  output logic                          outBad
);
  strobe_t strobe;

  pam6Control uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  pam6Datapath #(.SAMPLE_W(SAMPLE_W), .UNIT(UNIT)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inSamples (inSamples),
    .outData   (outData),
    .outBad    (outBad)
  );

  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(outData) && $stable(outBad)));
  a_r5_flag_needs_symbol: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outBad) |-> outValid);
endmodule

// File: tb/pam6SubsetDetector_test.sv
module pam6SubsetDetector_test;
  localparam int W = 6;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           inValid = 1'b0;
  logic [4*W-1:0] inSamples = '0;
  logic           outValid;
  logic [6:0]     outData;
  logic           outBad;

  int checks = 0;
  int errors = 0;

  // pipeline of expectations, two deep
  logic pv1 = 0, pv2 = 0;
  logic [7:0] pe1 = 0, pe2 = 0;     // {bad, data}
  logic [7:0] held = 0;

  always #5 clk = ~clk;

  pam6SubsetDetector #(.SAMPLE_W(W), .UNIT(1)) uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSamples(inSamples),
    .outValid(outValid), .outData(outData), .outBad(outBad)
  );

  function automatic int idxA(int x);
    return (x < -3) ? 0 : (x < 1) ? 1 : 2;
  endfunction
  function automatic int idxB(int x);
    return (x < -1) ? 0 : (x < 3) ? 1 : 2;
  endfunction
  function automatic int levA(int i);
    return (i == 0) ? -5 : (i == 1) ? -1 : 3;
  endfunction
  function automatic int levB(int i);
    return (i == 0) ? -3 : (i == 1) ? 1 : 5;
  endfunction

  // R4 mapping; returns 4'b1000 for the excluded (0,0) position
  function automatic logic [3:0] pairCode(int i, int j);
    case (i*3 + j)
      1: return 4'b0000;
      2: return 4'b0001;
      5: return 4'b0011;
      4: return 4'b0010;
      3: return 4'b0110;
      6: return 4'b0111;
      7: return 4'b0101;
      8: return 4'b0100;
      default: return 4'b1000;
    endcase
  endfunction

  function automatic int sqNear(int x, logic useB);
    int best = 1 << 30;
    for (int i = 0; i < 3; i++) begin
      int l = useB ? levB(i) : levA(i);
      if ((x - l) * (x - l) < best) best = (x - l) * (x - l);
    end
    return best;
  endfunction

  function automatic logic [7:0] model(int s0, int s1, int s2, int s3);
    int s [4];
    int dA = 0, dB = 0;
    logic b;
    int ix [4];
    logic [3:0] c0, c1;
    s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
    for (int k = 0; k < 4; k++) begin
      dA += sqNear(s[k], 1'b0);
      dB += sqNear(s[k], 1'b1);
    end
    b = (dA > dB);
    for (int k = 0; k < 4; k++) ix[k] = b ? idxB(s[k]) : idxA(s[k]);
    c0 = pairCode(ix[0], ix[1]);
    c1 = pairCode(ix[2], ix[3]);
    return {c0[3] | c1[3], b, c1[2:0], c0[2:0]};
  endfunction

  task automatic check(string req, logic ok, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: check outputs, then drive the next input at the falling edge
  task automatic step(logic v, int s0, int s1, int s2, int s3);
    logic [7:0] act;
    @(negedge clk);
    act = {outBad, outData};
    check("R1 valid latency", outValid == pv2, {7'd0, outValid}, {7'd0, pv2});
    if (pv2) begin
      check("R2/R3/R4/R5/R8 detected symbol", act == pe2, act, pe2);
      held = pe2;
    end else begin
      check("R6 hold between symbols", act == held, act, held);
    end
    pv2 = pv1; pe2 = pe1;
    pv1 = v;   pe1 = model(s0, s1, s2, s3);
    inValid = v;
    inSamples = {W'(s3), W'(s2), W'(s1), W'(s0)};
  endtask

  function automatic int rndSample();
    if ($urandom_range(7) == 0) return int'($urandom_range(63)) - 32;
    begin
      int l = int'($urandom_range(5)) * 2 - 5;
      return l + int'($urandom_range(4)) - 2;
    end
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R7: reset state
    check("R7 reset outputs", {outValid, outBad, outData} == 9'd0,
          {outBad, outData}, 8'd0);
    rstN = 1'b1;
    repeat (2) step(1'b0, 0, 0, 0, 0);
    check("R7 idle after reset", {outValid, outBad, outData} == 9'd0,
          {outBad, outData}, 8'd0);

    // R2 tie -> group A, all lines index 1 -> 0_010_010
    step(1'b1, 0, 0, 0, 0);
    // R5 far negative: group A, both pairs excluded
    step(1'b1, -32, -32, -32, -32);
    // R3 thresholds exactly
    step(1'b1, -3, 1, -1, 3);
    step(1'b1, -4, 0, -2, 2);
    step(1'b1, 31, 31, 31, 31);
    step(1'b1, -3, -3, -3, -3);
    step(1'b0, 0, 0, 0, 0);
    step(1'b0, 0, 0, 0, 0);
    step(1'b0, 0, 0, 0, 0);
    // direct expectations against the written tables
    check("R2 tie resolves to A", model(0, 0, 0, 0) == 8'b0_0_010_010,
          model(0, 0, 0, 0), 8'b0_0_010_010);
    check("R5 excluded corner flag", model(-32, -32, -32, -32) == 8'b1_0_000_000,
          model(-32, -32, -32, -32), 8'b1_0_000_000);

    // R9: every legal noiseless symbol, back to back (R8)
    for (int d = 0; d < 128; d++) begin
      int ix [4];
      int lv [4];
      for (int p = 0; p < 2; p++)
        for (int c = 0; c < 9; c++)
          if (pairCode(c / 3, c % 3) == {1'b0, 3'(d >> (3*p))}) begin
            ix[2*p] = c / 3; ix[2*p+1] = c % 3;
          end
      for (int k = 0; k < 4; k++) lv[k] = d[6] ? levB(ix[k]) : levA(ix[k]);
      check("R9 noiseless roundtrip model",
            model(lv[0], lv[1], lv[2], lv[3]) == {1'b0, 7'(d)},
            model(lv[0], lv[1], lv[2], lv[3]), {1'b0, 7'(d)});
      step(1'b1, lv[0], lv[1], lv[2], lv[3]);
    end

    // random traffic with gaps
    for (int n = 0; n < 3000; n++)
      step($urandom_range(3) != 0, rndSample(), rndSample(), rndSample(), rndSample());
    repeat (3) step(1'b0, 0, 0, 0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule